// File: doc/BRIEF.md
# Multi-Channel Timer Capture Unit

This block keeps four 16-bit snapshot registers of a free-running timer. Each channel is armed by one of two triggers: a level change on its own input pin, or a software strobe that marks a write to the low byte of that channel's register. Channel 0 sits beside the reload path and can watch for either edge direction. Channels 1 to 3 watch for rising edges only, and each has a sticky interrupt request flag.

Pins are sampled once per machine cycle, which is marked by a one-clock enable. An edge is recognised from two consecutive samples. The snapshot is taken on the next machine-cycle enable. A write trigger is latched on the machine-cycle enable after the strobe. Trigger type and enable are chosen separately for each channel. Interrupt flags stay set until their own clear strobe, and a set wins over a clear that arrives at the same time.

Top module: `tcap_unit`

## Requirements
- R1: A capture copies all 16 bits of `timerVal` into the channel's register as one operation. Channel k occupies `capVal[16k+15:16k]`. Channels that trigger at the same edge all receive the same value.
- R2: `modeSel[k]` selects the trigger for channel k: 0 is pin edge, 1 is write strobe. The inactive trigger has no effect. Channels may use different trigger types at the same time.
- R3: In pin mode, channels 1 to 3 capture on a rising pin edge only. A falling edge causes no capture.
- R4: In pin mode, channel 0 captures on a rising edge when `ch0RiseSel` is 1 and on a falling edge when it is 0. The other direction is ignored.
- R5: With `cycleEn` high, a pin change set up before clock edge E0 is recognised at E1 and loaded at E2 with the `timerVal` present at E2. The register is unchanged after E1. No register loads at an edge where `cycleEn` is low.
- R6: In write mode, a `lowWrStb[k]` pulse seen at edge E0 loads the register at the next edge with `cycleEn` high. The register is unchanged after E0.
- R7: For channels 1 to 3 in pin mode, `irqFlag[k-1]` is set at the edge where the rising edge is recognised. Write-mode captures set no flag.
- R8: A set flag stays set until `flagClr[k-1]` is seen high. When a set and a clear occur at the same edge, the flag ends up set.
- R9: While `chanEnable[k]` is 0, channel k neither loads nor sets its flag, whatever its pin or strobe does.
- R10: Reset clears all registers and flags. The first machine cycle after reset loads both pin samples from the pins, so a pin held at any level through reset gives no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycleEn | input | 1 | Machine-cycle enable |
| timerVal | input | 16 | Running timer value |
| capPin | input | 4 | External trigger pins, one per channel |
| lowWrStb | input | 4 | Low-byte write strobes, one per channel |
| chanEnable | input | 4 | Per-channel capture enable |
| modeSel | input | 4 | Per-channel trigger select (0 pin, 1 write) |
| ch0RiseSel | input | 1 | Channel 0 edge polarity (1 rising, 0 falling) |
| flagClr | input | 3 | Clear strobes for the flags of channels 1 to 3 |
| irqFlag | output | 3 | Interrupt request flags of channels 1 to 3 |
| capVal | output | 64 | Four captured timer values, packed |

## Verification
Two pairs of events can fall on the same edge. A pin-edge capture on channel 1 can land on the same edge as a write-strobe capture on channel 2. A flag set on channel 1 can meet that flag's clear strobe. The bench times the channel 1 pin change one cycle ahead of the channel 2 strobe, so both loads fall on the same edge. It also holds the clear strobe high across the recognition edge. It then requires both registers to equal the one timer value present at that edge, and the flag to read set, before a lone clear empties it.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  parameter int CAP_CH = 4;

  typedef struct packed {
    logic [CAP_CH-1:0] load;
  } capStb_t;
endpackage

// File: rtl/tcap_ctrl.sv
module tcap_ctrl
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleEn,
  input  logic [CAP_CH-1:0] capPin,
  input  logic [CAP_CH-1:0] lowWrStb,
  input  logic [CAP_CH-1:0] chanEnable,
  input  logic [CAP_CH-1:0] modeSel,
  input  logic              ch0RiseSel,
  input  logic [CAP_CH-2:0] flagClr,
  output logic [CAP_CH-2:0] irqFlag,
  output capStb_t           stb
);
  localparam int N = CAP_CH;

  logic          primed;
  logic [N-1:0]  sampNow, sampPrev;
  logic [N-1:0]  edgeCond, edgeHit, wrHit, capPend;
  logic [N-2:0]  flagQ;

  // R10: the first machine cycle loads both samples from the pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      sampNow  <= '0;
      sampPrev <= '0;
    end else if (cycleEn) begin
      primed   <= 1'b1;
      sampPrev <= primed ? sampNow : capPin;
      sampNow  <= capPin;
    end
  end

  // R3, R4: edge direction per channel
  for (genvar i = 0; i < N; i++) begin : g_edge
    if (i == 0) begin : g_ch0
      assign edgeCond[i] = ch0RiseSel ? (~sampPrev[i] & sampNow[i])
                                      : (sampPrev[i] & ~sampNow[i]);
    end else begin : g_chn
      assign edgeCond[i] = ~sampPrev[i] & sampNow[i];
    end
  end

  // R2, R9: trigger qualification
  always_comb begin
    edgeHit = {N{cycleEn & primed}} & chanEnable & ~modeSel & edgeCond;
    wrHit   = lowWrStb & chanEnable & modeSel;
  end

  // R5, R6: pending capture waits for the next machine-cycle enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capPend <= '0;
    else       capPend <= chanEnable & ((capPend & ~{N{cycleEn}}) | edgeHit | wrHit);
  end

  assign stb.load = capPend & chanEnable & {N{cycleEn}};

  // R7, R8: sticky flags for channels 1..N-1, set has priority
  for (genvar j = 1; j < N; j++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[j-1] <= 1'b0;
      else       flagQ[j-1] <= edgeHit[j] | (flagQ[j-1] & ~flagClr[j-1]);
    end
  end

  assign irqFlag = flagQ;
endmodule

// File: rtl/tcap_datapath.sv
module tcap_datapath
  import tcap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [TW-1:0]        timerVal,
  input  capStb_t              stb,
  output logic [CAP_CH*TW-1:0] capVal
);
  // R1: whole timer word copied in one load
  for (genvar i = 0; i < CAP_CH; i++) begin : g_reg
    logic [TW-1:0] capReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              capReg <= '0;
      else if (stb.load[i])   capReg <= timerVal;
    end
    assign capVal[i*TW +: TW] = capReg;
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cycleEn,
  input  logic [TW-1:0]        timerVal,
  input  logic [CAP_CH-1:0]    capPin,
  input  logic [CAP_CH-1:0]    lowWrStb,
  input  logic [CAP_CH-1:0]    chanEnable,
  input  logic [CAP_CH-1:0]    modeSel,
  input  logic                 ch0RiseSel,
  input  logic [CAP_CH-2:0]    flagClr,
  output logic [CAP_CH-2:0]    irqFlag,
  output logic [CAP_CH*TW-1:0] capVal
);
  capStb_t stb;

  tcap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .capPin(capPin),
    .lowWrStb(lowWrStb), .chanEnable(chanEnable), .modeSel(modeSel),
    .ch0RiseSel(ch0RiseSel), .flagClr(flagClr), .irqFlag(irqFlag), .stb(stb)
  );

  tcap_datapath #(.TW(TW)) u_dp (
    .clk(clk), .rstN(rstN), .timerVal(timerVal), .stb(stb), .capVal(capVal)
  );
endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk
  import tcap_pkg::*;
#(
  parameter int TW = 16
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cycleEn,
  input logic [CAP_CH-1:0]    chanEnable,
  input logic [CAP_CH-1:0]    modeSel,
  input logic [CAP_CH-2:0]    flagClr,
  input logic [CAP_CH-2:0]    irqFlag,
  input logic [CAP_CH*TW-1:0] capVal
);
  // R5
  idle_cycle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cycleEn) |-> $stable(capVal));

  for (genvar i = 0; i < CAP_CH; i++) begin : g_ch
    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(chanEnable[i]) |-> $stable(capVal[i*TW +: TW]));
  end

  for (genvar j = 1; j < CAP_CH; j++) begin : g_fl
    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
      irqFlag[j-1] && !flagClr[j-1] |=> irqFlag[j-1]);
    // R7
    no_write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$past(irqFlag[j-1]) && $past(modeSel[j] | ~chanEnable[j]) |-> !irqFlag[j-1]);
  end
endmodule

bind tcap_unit tcap_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .chanEnable(chanEnable),
  .modeSel(modeSel), .flagClr(flagClr), .irqFlag(irqFlag), .capVal(capVal)
);

// File: tb/tcap_unit_test.sv
module tcap_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int TW = 16;
  localparam int NVEC = 15;
  localparam logic [1:0] ST_RISE = 2'd0, ST_FALL = 2'd1, ST_WRITE = 2'd2;

  // fields: [8:7] channel, [6] mode, [5] enable, [4] ch0 polarity,
  //         [3:2] stimulus, [1] capture expected, [0] flag expected
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b1, 1'b0, ST_RISE,  1'b1, 1'b1},  // R3 R7
    {2'd1, 1'b0, 1'b1, 1'b0, ST_FALL,  1'b0, 1'b0},  // R3
    {2'd2, 1'b0, 1'b1, 1'b0, ST_RISE,  1'b1, 1'b1},  // R3 R7
    {2'd3, 1'b0, 1'b1, 1'b0, ST_RISE,  1'b1, 1'b1},  // R3 R7
    {2'd3, 1'b0, 1'b1, 1'b0, ST_FALL,  1'b0, 1'b0},  // R3
    {2'd0, 1'b0, 1'b1, 1'b1, ST_RISE,  1'b1, 1'b0},  // R4
    {2'd0, 1'b0, 1'b1, 1'b1, ST_FALL,  1'b0, 1'b0},  // R4
    {2'd0, 1'b0, 1'b1, 1'b0, ST_FALL,  1'b1, 1'b0},  // R4
    {2'd0, 1'b0, 1'b1, 1'b0, ST_RISE,  1'b0, 1'b0},  // R4
    {2'd2, 1'b1, 1'b1, 1'b0, ST_WRITE, 1'b1, 1'b0},  // R6 R7
    {2'd2, 1'b1, 1'b1, 1'b0, ST_RISE,  1'b0, 1'b0},  // R2
    {2'd1, 1'b0, 1'b1, 1'b0, ST_WRITE, 1'b0, 1'b0},  // R2
    {2'd0, 1'b1, 1'b1, 1'b0, ST_WRITE, 1'b1, 1'b0},  // R6
    {2'd3, 1'b0, 1'b0, 1'b0, ST_RISE,  1'b0, 1'b0},  // R9
    {2'd1, 1'b1, 1'b0, 1'b0, ST_WRITE, 1'b0, 1'b0}   // R9
  };

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            cycleEn = 1'b1;
  logic [TW-1:0]   timerVal = 16'h0001;
  logic [N-1:0]    capPin = '0;
  logic [N-1:0]    lowWrStb = '0;
  logic [N-1:0]    chanEnable = '0;
  logic [N-1:0]    modeSel = '0;
  logic            ch0RiseSel = 1'b0;
  logic [N-2:0]    flagClr = '0;
  logic [N-2:0]    irqFlag;
  logic [N*TW-1:0] capVal;

  int checks = 0;
  int fails = 0;
  logic [TW-1:0] edgeTmr = '0;
  bit done = 1'b0;

  tcap_unit #(.TW(TW)) uut (
    .clk(clk), .rstN(rstN), .cycleEn(cycleEn), .timerVal(timerVal),
    .capPin(capPin), .lowWrStb(lowWrStb), .chanEnable(chanEnable),
    .modeSel(modeSel), .ch0RiseSel(ch0RiseSel), .flagClr(flagClr),
    .irqFlag(irqFlag), .capVal(capVal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [TW-1:0] capOf(input int ch);
    return capVal[ch*TW +: TW];
  endfunction

  task automatic tick();
    @(posedge clk);
    edgeTmr = timerVal;
    @(negedge clk);
    timerVal = timerVal + 16'h1357;
  endtask

  task automatic chk(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] base;
    @(negedge clk);
    tick();
    chk("R10 reset capVal", capVal[TW-1:0] | capVal[TW +: TW] | capVal[2*TW +: TW] | capVal[3*TW +: TW], '0);
    chk("R10 reset flags", {13'd0, irqFlag}, '0);
    rstN = 1'b1;
    tick();

    for (int e = 0; e < NVEC; e++) begin
      int ch;
      logic [1:0] st;
      ch = int'(VEC[e][8:7]);
      st = VEC[e][3:2];
      modeSel[ch] = VEC[e][6];
      chanEnable[ch] = VEC[e][5];
      ch0RiseSel = VEC[e][4];
      capPin[ch] = (st == ST_FALL);
      for (int k = 0; k < 4; k++) tick();
      flagClr = '1;
      tick();
      flagClr = '0;
      base = capOf(ch);
      if (st == ST_WRITE) begin
        lowWrStb[ch] = 1'b1;
        tick();
        lowWrStb[ch] = 1'b0;
        chk($sformatf("R6 vec%0d not yet loaded", e), capOf(ch), base);
        tick();
      end else begin
        capPin[ch] = (st == ST_RISE);
        tick();
        tick();
        chk($sformatf("R5 vec%0d not yet loaded", e), capOf(ch), base);
        tick();
      end
      chk($sformatf("R2 R3 R4 R9 vec%0d capture", e), capOf(ch),
          VEC[e][1] ? edgeTmr : base);
      if (ch != 0)
        chk($sformatf("R7 R9 vec%0d flag", e), {15'd0, irqFlag[ch-1]}, {15'd0, VEC[e][0]});
    end

    // R1: all channels in write mode, one strobe each
    chanEnable = '1;
    modeSel = '1;
    lowWrStb = '1;
    tick();
    lowWrStb = '0;
    tick();
    for (int c = 0; c < N; c++) chk($sformatf("R1 ch%0d", c), capOf(c), edgeTmr);

    // R2 R8: pin capture on ch1 and write capture on ch2 on the same edge
    modeSel = 4'b0100;
    capPin = '0;
    for (int k = 0; k < 4; k++) tick();
    flagClr = '1;
    tick();
    flagClr = '0;
    capPin[1] = 1'b1;
    tick();
    lowWrStb[2] = 1'b1;
    flagClr[0] = 1'b1;
    tick();
    lowWrStb[2] = 1'b0;
    flagClr[0] = 1'b0;
    chk("R8 set wins over clear", {15'd0, irqFlag[0]}, 16'd1);
    tick();
    chk("R2 mixed ch1 pin", capOf(1), edgeTmr);
    chk("R2 mixed ch2 write", capOf(2), edgeTmr);
    chk("R8 flag held", {15'd0, irqFlag[0]}, 16'd1);
    flagClr[0] = 1'b1;
    tick();
    flagClr[0] = 1'b0;
    chk("R8 clear", {15'd0, irqFlag[0]}, 16'd0);

    // R5: loads wait for the machine-cycle enable
    modeSel[3] = 1'b1;
    cycleEn = 1'b0;
    base = capOf(3);
    lowWrStb[3] = 1'b1;
    tick();
    lowWrStb[3] = 1'b0;
    tick();
    tick();
    chk("R5 held while cycleEn low", capOf(3), base);
    cycleEn = 1'b1;
    tick();
    chk("R5 loaded on cycleEn", capOf(3), edgeTmr);

    // R10: pins high through reset give no false edge
    modeSel = '0;
    ch0RiseSel = 1'b1;
    capPin = '1;
    rstN = 1'b0;
    tick();
    chk("R10 second reset capVal", capVal[TW-1:0] | capVal[TW +: TW] | capVal[2*TW +: TW] | capVal[3*TW +: TW], '0);
    rstN = 1'b1;
    for (int k = 0; k < 5; k++) tick();
    chk("R10 no false capture", capVal[TW-1:0] | capVal[TW +: TW] | capVal[2*TW +: TW] | capVal[3*TW +: TW], '0);
    chk("R10 no false flag", {13'd0, irqFlag}, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule